// File: doc/BRIEF.md
# Ethernet Destination Address Filter

This block decides whether a received Ethernet frame should be kept, judging only by its destination address and length. Software, or a configuration sequencer, writes the station's own 48-bit address through a write port. It then streams a list of group addresses, one byte per clock, into a hash loader. The loader condenses that list into a 64-bit bitmap. For each address it takes bits 7..2 of the standard reflected CRC-32 (polynomial 0xEDB88320, seed all ones, result inverted), with the address bytes fed first byte first and least significant bit first within each byte.

The receive path offers a destination address, the frame length and four configuration inputs: minimum length, promiscuous, broadcast disable and group enable. Two clock edges after a request is taken, it gets back a strobe, an accept bit and a group flag. The group flag marks frames that were kept because they are broadcast or hashed multicast. While the loader is still hashing, the check port holds off new requests.

Top module: `addr_filter`

## Requirements
- R1: After reset, `valid_o`, `accept_o`, `group_o` and `ld_ready_o` are 0, `chk_ready_o` is 1, and the hash bitmap is empty.
- R2: A request whose `chk_len_i` is below `cfg_min_len_i` is rejected with `group_o`=0, whatever the address and the other flags.
- R3: With `cfg_promisc_i`=1, every request that passes the length test is accepted with `group_o`=0.
- R4: A destination of all ones is rejected when `cfg_bc_dis_i`=1. Otherwise it is accepted with `group_o`=1.
- R5: A destination with bit 40 set (bit 0 of the first byte on the wire, `chk_dst_i[47:40]`), other than all ones, is rejected when `cfg_mc_en_i`=0.
- R6: With `cfg_mc_en_i`=1, such a group destination is accepted, with `group_o`=1, exactly when bitmap bit `crc[7:2]` is set. Here `crc` is the inverted reflected CRC-32 over the six address bytes, first byte `[47:40]` first and LSB first within each byte.
- R7: Any other destination is accepted (`group_o`=0) only if it equals the station address last written with `ia_we_i`.
- R8: `ld_start_i` clears the whole bitmap and arms min(`ld_len_i`/6, 64) entries. Each following group of six bytes accepted with `ld_valid_i` and `ld_ready_o` sets one bit. Once the armed entries are used up, `ld_ready_o` is 0 and further bytes are ignored.
- R9: A request taken with `chk_valid_i` and `chk_ready_o` both high yields exactly one `valid_o` pulse two cycles later. A request offered while `chk_ready_o` is 0 yields none.
- R10: `chk_ready_o` is 0 while armed entries remain, and for one more cycle after the last byte of the list is taken.
- R11: `ld_start_i` during a load discards the partial list and restarts from an empty bitmap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ia_we_i | input | 1 | Write station address |
| ia_data_i | input | 48 | Station address, first wire byte in [47:40] |
| ld_start_i | input | 1 | Begin new group list, clears bitmap |
| ld_len_i | input | LEN_W | List length in bytes |
| ld_valid_i | input | 1 | List byte present |
| ld_byte_i | input | 8 | List byte |
| ld_ready_o | output | 1 | Loader takes a byte this cycle |
| chk_valid_i | input | 1 | Check request |
| chk_ready_o | output | 1 | Check port accepts a request |
| chk_dst_i | input | 48 | Destination address, first wire byte in [47:40] |
| chk_len_i | input | LEN_W | Frame length |
| cfg_min_len_i | input | LEN_W | Minimum accepted length |
| cfg_promisc_i | input | 1 | Accept every address |
| cfg_bc_dis_i | input | 1 | Reject broadcast |
| cfg_mc_en_i | input | 1 | Enable hashed group reception |
| valid_o | output | 1 | Decision strobe |
| accept_o | output | 1 | Frame kept |
| group_o | output | 1 | Kept as broadcast or group frame |

## Verification
The hash loader finishing its last entry and the check port taking a request can meet in one cycle. This happens where the final list byte is taken and the bitmap write is still one done strobe away. The bench drives `chk_valid_i` in the cycle right after that last byte and expects no decision strobe two cycles on. It then retries the same group address once `chk_ready_o` returns, and expects a decision made against the freshly loaded bitmap. Restarting a list halfway through an address, and hitting the 64-entry cap, are driven the same way around the loader's final byte.

// File: rtl/af_pkg.sv
package af_pkg;
  localparam int unsigned MAC_W    = 48;
  localparam int unsigned MAC_BYTES = MAC_W / 8;
  localparam logic [31:0] CRC_POLY = 32'hEDB88320;

  typedef struct packed {
    logic promisc;
    logic bc_dis;
    logic mc_en;
  } af_cfg_t;

  function automatic logic [31:0] crc_byte(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[0] ^ d[i]) r = (r >> 1) ^ CRC_POLY;
      else             r = r >> 1;
    end
    return r;
  endfunction

  function automatic logic [31:0] crc_mac(input logic [MAC_W-1:0] a);
    logic [31:0] r;
    r = '1;
    for (int k = 0; k < MAC_BYTES; k++) r = crc_byte(r, a[MAC_W-1-8*k -: 8]);
    return ~r;
  endfunction
endpackage

// File: rtl/af_crc_unit.sv
module af_crc_unit (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        clr_i,
  input  logic        vld_i,
  input  logic [7:0]  byte_i,
  input  logic        last_i,
  output logic        done_o,
  output logic [31:0] crc_o
);
  import af_pkg::*;

  logic [31:0] crc_q, res_q, crc_nx;
  logic        done_q;

  assign crc_nx = crc_byte(crc_q, byte_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      crc_q  <= '1;
      res_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (clr_i) begin
        crc_q <= '1;
      end else if (vld_i) begin
        if (last_i) begin
          crc_q  <= '1;
          res_q  <= ~crc_nx;
          done_q <= 1'b1;
        end else begin
          crc_q <= crc_nx;
        end
      end
    end
  end

  assign done_o = done_q;
  assign crc_o  = res_q;
endmodule

// File: rtl/af_hash_table.sv
module af_hash_table #(
  parameter int unsigned IDX_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             set_i,
  input  logic [IDX_W-1:0] set_idx_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic             hit_o
);
  localparam int unsigned ROWS = (1 << IDX_W) / 8;

  logic [ROWS*8-1:0] tbl;

  for (genvar g = 0; g < ROWS; g++) begin : g_row
    logic [7:0] row_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                    row_q <= '0;
      else if (clr_i)                                 row_q <= '0;
      else if (set_i && set_idx_i[IDX_W-1:3] == g)    row_q[set_idx_i[2:0]] <= 1'b1;
    end
    assign tbl[g*8 +: 8] = row_q;
  end

  assign hit_o = tbl[rd_idx_i];
endmodule

// File: rtl/af_decide.sv
module af_decide #(
  parameter int unsigned LEN_W = 16,
  parameter int unsigned IDX_W = 6
) (
  input  logic [af_pkg::MAC_W-1:0] dst_i,
  input  logic [LEN_W-1:0]         len_i,
  input  logic [LEN_W-1:0]         min_len_i,
  input  af_pkg::af_cfg_t          cfg_i,
  input  logic [af_pkg::MAC_W-1:0] ia_i,
  output logic [IDX_W-1:0]         idx_o,
  input  logic                     hit_i,
  output logic                     accept_o,
  output logic                     group_o
);
  import af_pkg::*;

  logic [31:0] crc;
  logic short_f, bcast_f, multi_f;

  assign crc     = crc_mac(dst_i);
  assign idx_o   = crc[IDX_W+1:2];
  assign short_f = len_i < min_len_i;
  assign bcast_f = &dst_i;
  assign multi_f = dst_i[MAC_W-8];

  always_comb begin
    accept_o = 1'b0;
    group_o  = 1'b0;
    if (short_f) begin
      accept_o = 1'b0;
    end else if (cfg_i.promisc) begin
      accept_o = 1'b1;
    end else if (bcast_f) begin
      accept_o = !cfg_i.bc_dis;
      group_o  = !cfg_i.bc_dis;
    end else if (multi_f) begin
      accept_o = cfg_i.mc_en && hit_i;
      group_o  = cfg_i.mc_en && hit_i;
    end else begin
      accept_o = (dst_i == ia_i);
    end
  end
endmodule

// File: rtl/addr_filter.sv
module addr_filter #(
  parameter int unsigned LEN_W = 16,
  parameter int unsigned IDX_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ia_we_i,
  input  logic [47:0]      ia_data_i,
  input  logic             ld_start_i,
  input  logic [LEN_W-1:0] ld_len_i,
  input  logic             ld_valid_i,
  input  logic [7:0]       ld_byte_i,
  output logic             ld_ready_o,
  input  logic             chk_valid_i,
  output logic             chk_ready_o,
  input  logic [47:0]      chk_dst_i,
  input  logic [LEN_W-1:0] chk_len_i,
  input  logic [LEN_W-1:0] cfg_min_len_i,
  input  logic             cfg_promisc_i,
  input  logic             cfg_bc_dis_i,
  input  logic             cfg_mc_en_i,
  output logic             valid_o,
  output logic             accept_o,
  output logic             group_o
);
  import af_pkg::*;

  localparam int unsigned MAX_ENT = 1 << IDX_W;
  localparam int unsigned ENT_W   = IDX_W + 1;

  logic [MAC_W-1:0] ia_q;
  logic [ENT_W-1:0] left_q, ent_cnt;
  logic [2:0]       bidx_q;
  logic [LEN_W-1:0] n_addr;
  logic             byte_acc, last_b, crc_done;
  logic [31:0]      crc_res;

  assign n_addr   = ld_len_i / LEN_W'(MAC_BYTES);
  assign ent_cnt  = (n_addr > LEN_W'(MAX_ENT)) ? ENT_W'(MAX_ENT) : n_addr[ENT_W-1:0];
  assign byte_acc = ld_valid_i && ld_ready_o && !ld_start_i;
  assign last_b   = (bidx_q == 3'(MAC_BYTES - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ia_q <= '0;
    else if (ia_we_i) ia_q <= ia_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      left_q <= '0;
      bidx_q <= '0;
    end else if (ld_start_i) begin
      left_q <= ent_cnt;
      bidx_q <= '0;
    end else if (byte_acc) begin
      if (last_b) begin
        bidx_q <= '0;
        left_q <= left_q - 1'b1;
      end else begin
        bidx_q <= bidx_q + 1'b1;
      end
    end
  end

  assign ld_ready_o = (left_q != '0);

  af_crc_unit u_crc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (ld_start_i),
    .vld_i  (byte_acc),
    .byte_i (ld_byte_i),
    .last_i (last_b),
    .done_o (crc_done),
    .crc_o  (crc_res)
  );

  // hold checks off until the final bitmap write has landed
  assign chk_ready_o = (left_q == '0) && !crc_done;

  logic             s1_v;
  logic [MAC_W-1:0] s1_dst;
  logic [LEN_W-1:0] s1_len, s1_min;
  af_cfg_t          s1_cfg;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_v   <= 1'b0;
      s1_dst <= '0;
      s1_len <= '0;
      s1_min <= '0;
      s1_cfg <= '0;
    end else begin
      s1_v <= chk_valid_i && chk_ready_o;
      if (chk_valid_i && chk_ready_o) begin
        s1_dst <= chk_dst_i;
        s1_len <= chk_len_i;
        s1_min <= cfg_min_len_i;
        s1_cfg <= '{promisc: cfg_promisc_i, bc_dis: cfg_bc_dis_i, mc_en: cfg_mc_en_i};
      end
    end
  end

  logic [IDX_W-1:0] rd_idx;
  logic             hit, dec_acc, dec_grp;

  af_hash_table #(.IDX_W(IDX_W)) u_tbl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (ld_start_i),
    .set_i     (crc_done),
    .set_idx_i (crc_res[IDX_W+1:2]),
    .rd_idx_i  (rd_idx),
    .hit_o     (hit)
  );

  af_decide #(.LEN_W(LEN_W), .IDX_W(IDX_W)) u_dec (
    .dst_i     (s1_dst),
    .len_i     (s1_len),
    .min_len_i (s1_min),
    .cfg_i     (s1_cfg),
    .ia_i      (ia_q),
    .idx_o     (rd_idx),
    .hit_i     (hit),
    .accept_o  (dec_acc),
    .group_o   (dec_grp)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      accept_o <= 1'b0;
      group_o  <= 1'b0;
    end else begin
      valid_o  <= s1_v;
      accept_o <= s1_v && dec_acc;
      group_o  <= s1_v && dec_grp;
    end
  end
endmodule

// File: rtl/addr_filter_chk.sv
module addr_filter_chk #(
  parameter int unsigned LEN_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ld_start_i,
  input logic [LEN_W-1:0] ld_len_i,
  input logic             ld_ready_o,
  input logic             chk_valid_i,
  input logic             chk_ready_o,
  input logic [LEN_W-1:0] chk_len_i,
  input logic [LEN_W-1:0] cfg_min_len_i,
  input logic             valid_o,
  input logic             accept_o,
  input logic             group_o
);
  // R10: loader and check port never open together
  a_r10_no_overlap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(chk_ready_o && ld_ready_o));

  a_r9_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(chk_valid_i && chk_ready_o, 2));

  a_r9_quiet_outputs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (!accept_o && !group_o));

  a_r4_group_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    group_o |-> accept_o);

  a_r8_start_arms: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_start_i && ld_len_i >= LEN_W'(6)) |=> ld_ready_o);

  a_r2_short_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(chk_len_i < cfg_min_len_i, 2)) |-> !accept_o);
endmodule

bind addr_filter addr_filter_chk #(.LEN_W(LEN_W)) u_chk (.*);

// File: tb/addr_filter_tb.sv
`timescale 1ns/1ps
module addr_filter_tb;
  localparam int LEN_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic             ia_we = 0;
  logic [47:0]      ia_data = '0;
  logic             ld_start = 0;
  logic [LEN_W-1:0] ld_len = '0;
  logic             ld_valid = 0;
  logic [7:0]       ld_byte = '0;
  logic             ld_ready;
  logic             chk_valid = 0;
  logic             chk_ready;
  logic [47:0]      chk_dst = '0;
  logic [LEN_W-1:0] chk_len = '0;
  logic [LEN_W-1:0] min_len = '0;
  logic             promisc = 0, bc_dis = 0, mc_en = 0;
  logic             valid_o, accept_o, group_o;

  addr_filter #(.LEN_W(LEN_W), .IDX_W(6)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .ia_we_i(ia_we), .ia_data_i(ia_data),
    .ld_start_i(ld_start), .ld_len_i(ld_len), .ld_valid_i(ld_valid),
    .ld_byte_i(ld_byte), .ld_ready_o(ld_ready),
    .chk_valid_i(chk_valid), .chk_ready_o(chk_ready), .chk_dst_i(chk_dst),
    .chk_len_i(chk_len), .cfg_min_len_i(min_len), .cfg_promisc_i(promisc),
    .cfg_bc_dis_i(bc_dis), .cfg_mc_en_i(mc_en),
    .valid_o(valid_o), .accept_o(accept_o), .group_o(group_o)
  );

  int n_chk = 0, n_fail = 0;
  logic [63:0] m_tbl = '0;
  logic [47:0] m_ia = '0;
  int m_left = 0, m_bidx = 0;
  logic [47:0] lst [0:69];

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int tb_hash(input logic [47:0] a);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int k = 0; k < 6; k++)
      for (int j = 0; j < 8; j++) begin
        logic b = a[40 - 8*k + j];
        c = (c[0] ^ b) ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
      end
    c = ~c;
    return int'(c[7:2]);
  endfunction

  task automatic expect_dec(input logic [47:0] d, input int len, input int mn,
                            input bit p, input bit bd, input bit me,
                            output bit acc, output bit grp);
    acc = 0; grp = 0;
    if (len < mn) acc = 0;
    else if (p) acc = 1;
    else if (&d) begin acc = !bd; grp = !bd; end
    else if (d[40]) begin acc = me && m_tbl[tb_hash(d)]; grp = acc; end
    else acc = (d == m_ia);
  endtask

  task automatic do_check(input logic [47:0] d, input int len, input int mn,
                          input bit p, input bit bd, input bit me, input string req);
    bit ea, eg;
    int w = 0;
    @(negedge clk);
    while (!chk_ready && w < 20) begin @(negedge clk); w++; end
    chk_dst = d; chk_len = LEN_W'(len); min_len = LEN_W'(mn);
    promisc = p; bc_dis = bd; mc_en = me; chk_valid = 1;
    @(posedge clk); #1 chk_valid = 0;
    @(posedge clk); #1;
    expect_dec(d, len, mn, p, bd, me, ea, eg);
    chk(valid_o == 1'b1, {req, " valid"}, 64'(valid_o), 64'(1));
    chk(accept_o == ea && group_o == eg, {req, " decision"},
        {62'b0, accept_o, group_o}, {62'b0, ea, eg});
  endtask

  task automatic ld_begin(input int len);
    @(negedge clk);
    ld_start = 1; ld_len = LEN_W'(len);
    @(posedge clk);
    m_tbl = '0; m_bidx = 0; m_left = (len / 6 > 64) ? 64 : len / 6;
    #1 ld_start = 0;
  endtask

  task automatic ld_send(input logic [47:0] a, input int nb);
    for (int b = 0; b < nb; b++) begin
      bit acc;
      @(negedge clk);
      ld_valid = 1; ld_byte = a[47 - 8*b -: 8];
      acc = ld_ready;
      @(posedge clk);
      if (acc) begin
        m_bidx++;
        if (m_bidx == 6) begin m_bidx = 0; m_left--; m_tbl[tb_hash(a)] = 1'b1; end
      end
      #1 ld_valid = 0;
    end
  endtask

  function automatic logic [47:0] rnd_mac();
    return {$urandom, $urandom} & 48'hFFFF_FFFF_FFFF;
  endfunction

  initial begin
    #(200000 * 5);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", n_chk, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [47:0] mca;
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(!valid_o && !accept_o && !group_o, "R1 outputs idle", {61'b0, valid_o, accept_o, group_o}, 0);
    chk(!ld_ready, "R1 ld_ready low", 64'(ld_ready), 0);
    chk(chk_ready, "R1 chk_ready high", 64'(chk_ready), 1);
    do_check(48'h0100_5E00_0001, 64, 60, 0, 0, 1, "R1 empty bitmap");

    // R7 station address
    @(negedge clk); m_ia = 48'h0202_0304_0506; ia_data = m_ia; ia_we = 1;
    @(posedge clk); #1 ia_we = 0;
    do_check(m_ia, 64, 60, 0, 0, 0, "R7 match");
    do_check(m_ia ^ 48'h1, 64, 60, 0, 0, 0, "R7 mismatch");
    do_check(m_ia ^ 48'h0000_0000_8000, 64, 60, 0, 0, 1, "R7 mismatch mid");

    // R4 / R2 / R3
    do_check('1, 64, 60, 0, 0, 0, "R4 broadcast kept");
    do_check('1, 64, 60, 0, 1, 1, "R4 broadcast disabled");
    do_check('1, 59, 60, 0, 0, 1, "R2 short broadcast");
    do_check(m_ia, 20, 21, 1, 0, 1, "R2 short promisc");
    do_check(48'h0A0B_0C0D_0E0F, 60, 60, 1, 1, 0, "R3 promisc unicast");
    do_check('1, 60, 60, 1, 0, 0, "R3 promisc broadcast group low");

    // R6 / R5 load three addresses
    lst[0] = 48'h0100_5E00_00FB; lst[1] = 48'h3333_0000_0001; lst[2] = 48'h0180_C200_000E;
    ld_begin(18);
    @(negedge clk);
    chk(ld_ready && !chk_ready, "R10 check held during load", {62'b0, ld_ready, chk_ready}, 64'b10);
    for (int i = 0; i < 3; i++) ld_send(lst[i], 6);
    for (int i = 0; i < 3; i++) do_check(lst[i], 64, 60, 0, 0, 1, "R6 listed hit");
    for (int i = 0; i < 3; i++) do_check(lst[i], 64, 60, 0, 0, 0, "R5 group disabled");
    do_check(48'h0100_5E7F_1234, 64, 60, 0, 0, 1, "R6 unlisted");

    // R8 extra bytes ignored, zero-entry list
    ld_begin(7);
    ld_send(lst[0], 6);
    @(negedge clk);
    chk(!ld_ready, "R8 ready low after entries", 64'(ld_ready), 0);
    ld_send(lst[1], 6);
    do_check(lst[1], 64, 60, 0, 0, 1, "R8 surplus address ignored");
    do_check(lst[2], 64, 60, 0, 0, 1, "R8 bitmap cleared on start");
    ld_begin(5);
    @(negedge clk);
    chk(!ld_ready && chk_ready, "R8 zero entries", {62'b0, ld_ready, chk_ready}, 64'b01);
    do_check(lst[0], 64, 60, 0, 0, 1, "R8 empty after short list");

    // R8 cap at 64
    for (int i = 0; i < 70; i++) lst[i] = rnd_mac() | 48'h0100_0000_0000;
    ld_begin(70 * 6);
    for (int i = 0; i < 64; i++) ld_send(lst[i], 6);
    @(negedge clk);
    chk(!ld_ready, "R8 capped at 64 entries", 64'(ld_ready), 0);
    for (int i = 64; i < 66; i++) ld_send(lst[i], 6);
    for (int i = 60; i < 66; i++) do_check(lst[i], 64, 60, 0, 0, 1, "R8 cap decision");

    // R11 restart mid-list
    lst[0] = 48'h0100_5E01_0203; lst[1] = 48'h0100_5E0A_0B0C; lst[2] = 48'h3333_FF00_1122;
    ld_begin(12);
    ld_send(lst[0], 6);
    ld_send(lst[1], 3);
    ld_begin(6);
    ld_send(lst[2], 6);
    do_check(lst[0], 64, 60, 0, 0, 1, "R11 old entry dropped");
    do_check(lst[1], 64, 60, 0, 0, 1, "R11 partial entry dropped");
    do_check(lst[2], 64, 60, 0, 0, 1, "R11 new entry");

    // R10/R9 request colliding with load completion
    mca = 48'h0100_5E12_3456;
    ld_begin(6);
    ld_send(mca, 6);
    @(negedge clk);
    chk(!chk_ready, "R10 held during done strobe", 64'(chk_ready), 0);
    chk_dst = mca; chk_len = 64; min_len = 60; promisc = 0; bc_dis = 0; mc_en = 1;
    chk_valid = 1;
    @(posedge clk); #1 chk_valid = 0;
    chk(chk_ready, "R10 ready after done", 64'(chk_ready), 1);
    @(posedge clk); #1;
    chk(!valid_o, "R9 refused request gives no strobe", 64'(valid_o), 0);
    @(posedge clk); #1;
    chk(!valid_o, "R9 no late strobe", 64'(valid_o), 0);
    do_check(mca, 64, 60, 0, 0, 1, "R6 retry after load");

    // random mix
    for (int n = 0; n < 400; n++) begin
      logic [47:0] d;
      int cat = $urandom % 6;
      if (n % 80 == 0) begin
        int cnt = 1 + ($urandom % 8);
        for (int i = 0; i < cnt; i++) lst[i] = rnd_mac() | 48'h0100_0000_0000;
        ld_begin(cnt * 6 + ($urandom % 6));
        for (int i = 0; i < cnt; i++) ld_send(lst[i], 6);
      end
      case (cat)
        0: d = '1;
        1: d = lst[$urandom % 2];
        2: d = rnd_mac() | 48'h0100_0000_0000;
        3: d = m_ia;
        4: d = m_ia ^ (48'h1 << ($urandom % 40));
        default: d = rnd_mac() & ~48'h0100_0000_0000;
      endcase
      do_check(d, $urandom % 100, $urandom % 80, ($urandom % 5) == 0,
               $urandom % 2, ($urandom % 4) != 0, "R6 R7 R4 random");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule